// File: doc/BRIEF.md
# SPI Command-Stream Execution Engine

This block is an SPI master that is steered by a stream of 16-bit instruction words instead of by per-transaction registers. Each word is taken from a command port with a valid/ready handshake. The word moves bytes over the bus, sets the eight active-low chip selects, writes one of two internal settings (the SCLK divider and the bus mode), waits for a timed interval, or posts a marker ID that tells the host that every earlier instruction has completed.

Outgoing bytes come from a write-byte stream and incoming bytes go to a read-byte stream. Both are plain valid/ready ports, and the FIFO storage for them sits outside the block. A host builds a short program: set the mode, set the divider, assert a select, transfer, release the select and post a marker. It then waits for the marker to come back on the sync port. Every SCLK edge and delay is derived from a single tick generator whose period is `divider+1` reference clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: An instruction word is split into an opcode in bits [15:12], a first argument in bits [11:8] and a second argument in bits [7:0]. Opcode 0 transfers bytes, 1 sets the chip selects, 2 writes a setting and 3 selects sync or sleep. Opcodes 4 to 15, setting targets other than 0 and 1, and sub-functions other than 0 and 1 are accepted and change nothing.
- R2: While reset is held and directly after it, all eight selects are high, SCLK is low, the divider and the mode are 0, `mosi_oe` is 1, `sync_valid` is 0 and the command port is ready.
- R3: Opcode 1 copies the second argument onto `cs_n` in the cycle it is accepted. If the first argument d is not zero, the next instruction is accepted no earlier than 2*d*(div+1)+1 cycles later. Only this opcode changes `cs_n`.
- R4: A setting write to target 0 loads the divider from the second argument. During a byte, each SCLK half-period then lasts div+1 reference clocks.
- R5: A setting write to target 1 loads the mode from the low bits of the second argument: bit 0 is clock phase, bit 1 is idle clock level and bit 2 is single-data-line mode. SCLK rests at the idle level between bytes. With phase 0, MISO is sampled on the first, third and later odd edges. With phase 1 it is sampled on the even edges. Bytes travel MSB first.
- R6: Opcode 0 moves arg2+1 bytes. When bit 0 of the first argument is set, each byte is taken from the write stream. When it is clear, 0x00 is sent. When bit 1 is set, each received byte is offered on the read stream. When it is clear, nothing is offered.
- R7: A transfer whose write flag is set waits before each byte until a write byte is offered. SCLK does not toggle while it waits.
- R8: A transfer whose read flag is set does not begin a new byte while the previous read byte is still offered and not taken. While it is not taken, `rx_data` holds its value.
- R9: Opcode 3 with first argument 1 sleeps. The next instruction is accepted 2*(arg2+1)*(div+1)+1 cycles after the sleep is accepted.
- R10: Opcode 3 with first argument 0 pulses `sync_valid` for one cycle and sets `sync_id` to the second argument. The instruction is accepted only after every earlier byte, including the last read byte handed out, has completed.
- R11: When single-data-line mode is set, `mosi_oe` is 0 for the whole of a transfer whose write flag is clear. It stays 1 for transfers that write and at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Instruction word offered |
| cmd_ready | output | 1 | Engine takes the instruction word |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Write byte offered |
| tx_ready | output | 1 | Engine takes the write byte |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Read byte offered |
| rx_ready | input | 1 | Consumer takes the read byte |
| rx_data | output | 8 | Read byte |
| sync_valid | output | 1 | One-cycle marker pulse |
| sync_id | output | 8 | ID of the last marker reached |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out line |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
Full-duplex transfers are run in each of the four clock-phase and idle-level combinations, with random byte counts, random data and random dividers. A slave model samples MOSI and drives MISO on the edges of the selected mode, so a fault in edge choice or bit order corrupts the bytes in one direction. Read-only and write-only transfers in single-data-line mode separate the two transfer flags and the output-enable behaviour. A write stream held empty and a read stream held full show that the stall logic stops the clock at a byte boundary. Sleep and select-delay timing is measured from handshake to handshake. Unused opcodes and setting targets are followed by a transfer whose clock rate and idle level would show any stray write to the settings.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 8;
    localparam int DIV_W   = 8;

    localparam logic [3:0] OP_XFER = 4'd0;
    localparam logic [3:0] OP_SEL  = 4'd1;
    localparam logic [3:0] OP_SET  = 4'd2;
    localparam logic [3:0] OP_MISC = 4'd3;

    localparam logic [3:0] SET_DIV  = 4'd0;
    localparam logic [3:0] SET_MODE = 4'd1;

    localparam logic [3:0] MISC_MARK  = 4'd0;
    localparam logic [3:0] MISC_SLEEP = 4'd1;

    typedef struct packed {
        logic [3:0]        op;
        logic [3:0]        a1;
        logic [BYTE_W-1:0] a2;
    } insn_t;

    typedef struct packed {
        logic one_line;
        logic idle_hi;
        logic late_smp;
    } mode_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_SELDLY,
        ST_SLEEP,
        ST_XWAIT,
        ST_XRUN
    } state_e;

    function automatic insn_t split_word(input logic [WORD_W-1:0] w);
        return insn_t'(w);
    endfunction

    function automatic mode_t to_mode(input logic [2:0] bits);
        return mode_t'(bits);
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt <= div); // R4

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              late_smp,
    input  logic              idle_hi,
    input  logic              tick,
    input  logic              miso,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi
);

    localparam int EDGES = 2 * BYTE_W;
    localparam int EW    = $clog2(EDGES + 1);

    logic              busy;
    logic              ph;
    logic [EW-1:0]     edge_n;
    logic [BYTE_W-1:0] txs;
    logic [BYTE_W-1:0] rxs;
    logic              mosi_q;
    logic              lead;
    logic              smp;
    logic              last;

    assign lead = !edge_n[0];
    assign smp  = late_smp ? !lead : lead;
    assign last = (edge_n == EW'(EDGES - 1));
    assign done = busy && tick && last;

    assign rx_byte = smp ? {rxs[BYTE_W-2:0], miso} : rxs;
    assign sclk    = idle_hi ^ ph;
    assign mosi    = mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ph     <= 1'b0;
            edge_n <= '0;
            txs    <= '0;
            rxs    <= '0;
            mosi_q <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            ph     <= 1'b0;
            edge_n <= '0;
            if (!late_smp) begin
                mosi_q <= tx_byte[BYTE_W-1];
                txs    <= tx_byte << 1;
            end else begin
                txs    <= tx_byte;
            end
        end else if (busy && tick) begin
            ph     <= ~ph;
            edge_n <= edge_n + EW'(1);
            if (smp) begin
                rxs <= {rxs[BYTE_W-2:0], miso};
            end else if (!last) begin
                mosi_q <= txs[BYTE_W-1];
                txs    <= txs << 1;
            end
            if (last) begin
                busy   <= 1'b0;
                edge_n <= '0;
            end
        end
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk == idle_hi); // R5

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              sync_valid,
    output logic [BYTE_W-1:0] sync_id,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    output logic [SEL_W-1:0]  cs_n
);

    state_e            st;
    insn_t             ins;
    mode_t             mode;
    logic [DIV_W-1:0]  div;
    logic [DLY_W-1:0]  dly;
    logic [BYTE_W-1:0] xf_left;
    logic              xf_wr;
    logic              xf_rd;
    logic              cmd_fire;
    logic              can_start;
    logic              sh_start;
    logic              sh_done;
    logic [BYTE_W-1:0] sh_rx;
    logic              tick;
    logic              tick_en;

    assign ins       = split_word(cmd_data);
    assign cmd_ready = (st == ST_FETCH) && !rx_valid;
    assign cmd_fire  = cmd_valid && cmd_ready;

    assign can_start = (!xf_wr || tx_valid) && !(xf_rd && rx_valid);
    assign sh_start  = (st == ST_XWAIT) && can_start;
    assign tx_ready  = (st == ST_XWAIT) && xf_wr && !(xf_rd && rx_valid);
    assign tick_en   = (st == ST_SELDLY) || (st == ST_SLEEP) || (st == ST_XRUN);
    assign mosi_oe   = !(mode.one_line && !xf_wr &&
                         ((st == ST_XWAIT) || (st == ST_XRUN)));

    spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_en),
        .div  (div),
        .tick (tick)
    );

    spi_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (sh_start),
        .tx_byte  (xf_wr ? tx_data : '0),
        .late_smp (mode.late_smp),
        .idle_hi  (mode.idle_hi),
        .tick     (tick),
        .miso     (miso),
        .done     (sh_done),
        .rx_byte  (sh_rx),
        .sclk     (sclk),
        .mosi     (mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_FETCH;
            cs_n       <= '1;
            div        <= '0;
            mode       <= '0;
            dly        <= '0;
            xf_left    <= '0;
            xf_wr      <= 1'b0;
            xf_rd      <= 1'b0;
            sync_valid <= 1'b0;
            sync_id    <= '0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
        end else begin
            sync_valid <= 1'b0;
            if (rx_valid && rx_ready) begin
                rx_valid <= 1'b0;
            end
            case (st)
                ST_FETCH: begin
                    if (cmd_fire) begin
                        case (ins.op)
                            OP_XFER: begin
                                xf_wr   <= ins.a1[0];
                                xf_rd   <= ins.a1[1];
                                xf_left <= ins.a2;
                                st      <= ST_XWAIT;
                            end
                            OP_SEL: begin
                                cs_n <= ins.a2;
                                if (ins.a1 != '0) begin
                                    dly <= DLY_W'({ins.a1, 1'b0}) - DLY_W'(1);
                                    st  <= ST_SELDLY;
                                end
                            end
                            OP_SET: begin
                                if (ins.a1 == SET_DIV) begin
                                    div <= ins.a2;
                                end else if (ins.a1 == SET_MODE) begin
                                    mode <= to_mode(ins.a2[2:0]);
                                end
                            end
                            OP_MISC: begin
                                if (ins.a1 == MISC_MARK) begin
                                    sync_valid <= 1'b1;
                                    sync_id    <= ins.a2;
                                end else if (ins.a1 == MISC_SLEEP) begin
                                    dly <= DLY_W'({ins.a2, 1'b1});
                                    st  <= ST_SLEEP;
                                end
                            end
                            default: begin
                            end
                        endcase
                    end
                end
                ST_SELDLY, ST_SLEEP: begin
                    if (tick) begin
                        if (dly == '0) begin
                            st <= ST_FETCH;
                        end else begin
                            dly <= dly - DLY_W'(1);
                        end
                    end
                end
                ST_XWAIT: begin
                    if (can_start) begin
                        st <= ST_XRUN;
                    end
                end
                ST_XRUN: begin
                    if (sh_done) begin
                        if (xf_rd) begin
                            rx_valid <= 1'b1;
                            rx_data  <= sh_rx;
                        end
                        if (xf_left == '0) begin
                            st <= ST_FETCH;
                        end else begin
                            xf_left <= xf_left - BYTE_W'(1);
                            st      <= ST_XWAIT;
                        end
                    end
                end
                default: st <= ST_FETCH;
            endcase
        end
    end

    AST_SEL_BY_CMD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> $past(cmd_fire && ins.op == OP_SEL)); // R3
    AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        st == ST_FETCH |-> sclk == mode.idle_hi); // R5
    AST_NO_CLK_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        st == ST_XWAIT |=> $stable(sclk)); // R7
    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R8
    AST_MARK_SOURCE: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> $past(cmd_fire && ins.op == OP_MISC && ins.a1 == MISC_MARK)); // R10

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = '0;
    logic        tx_valid;
    logic        tx_ready;
    logic [7:0]  tx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic [7:0]  rx_data;
    logic        sync_valid;
    logic [7:0]  sync_id;
    logic        sclk;
    logic        mosi;
    logic        mosi_oe;
    logic        miso = 1'b0;
    logic [7:0]  cs_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fetch_cyc = 0;

    logic [7:0] tx_mem [0:63];
    int tx_wr = 0;
    int tx_rd = 0;
    logic tx_en = 1'b1;

    logic [7:0] rx_got [0:63];
    int rx_n = 0;

    logic m_cpha = 1'b0;
    logic m_cpol = 1'b0;
    logic [7:0] slv_got [0:63];
    int slv_n = 0;
    int s_idx, s_bit, s_nin, edges, gap_min, last_chg;
    logic [7:0] s_out, s_in;
    logic oe_low;
    logic [7:0] cs_prev = 8'hFF;
    logic sclk_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_engine uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sync_valid(sync_valid), .sync_id(sync_id),
        .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso),
        .cs_n(cs_n)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 53 + 60) ^ 8'hA5;
    endfunction

    function automatic int sleep_gap(input int a2, input int dv);
        return 2 * (a2 + 1) * (dv + 1) + 1;
    endfunction

    function automatic int sel_gap(input int d, input int dv);
        return 2 * d * (dv + 1) + 1;
    endfunction

    assign tx_valid = tx_en && (tx_rd != tx_wr);
    assign tx_data  = tx_mem[tx_rd[5:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_valid && tx_ready) tx_rd <= tx_rd + 1;
        if (rx_valid && rx_ready) begin
            rx_got[rx_n[5:0]] <= rx_data;
            rx_n <= rx_n + 1;
        end
        if (cyc == WD_LIMIT) begin
            $display("FAIL watchdog: run hung (actual cycle %0d, expected end before %0d)", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    // slave model: samples MOSI and drives MISO on the mode's edges
    always @(negedge clk) begin
        if (cs_n == 8'hFF) begin
            s_idx = 0;
            s_bit = 0;
            s_out = pat(0);
            miso  = s_out[7];
        end else begin
            if (cs_prev == 8'hFF) begin
                gap_min = 1000; edges = 0; oe_low = 1'b0;
                last_chg = cyc; s_nin = 0;
            end
            if (!mosi_oe) oe_low = 1'b1;
            if (sclk != sclk_prev) begin
                edges = edges + 1;
                if (edges > 1 && (cyc - last_chg) < gap_min) gap_min = cyc - last_chg;
                last_chg = cyc;
                if ((sclk != m_cpol) == !m_cpha) begin
                    s_in = {s_in[6:0], mosi};
                    s_nin = s_nin + 1;
                    if (s_nin == 8) begin
                        slv_got[slv_n[5:0]] = s_in;
                        slv_n = slv_n + 1;
                        s_nin = 0;
                    end
                end else if (!m_cpha) begin
                    s_bit = s_bit + 1;
                    if (s_bit == 8) begin
                        s_idx = s_idx + 1; s_out = pat(s_idx); s_bit = 0;
                    end
                    miso = s_out[7 - s_bit];
                end else begin
                    miso = s_out[7 - s_bit];
                    s_bit = s_bit + 1;
                    if (s_bit == 8) begin
                        s_idx = s_idx + 1; s_out = pat(s_idx); s_bit = 0;
                    end
                end
            end
        end
        cs_prev   = cs_n;
        sclk_prev = sclk;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        fetch_cyc = cyc;
    endtask

    task automatic set_div(input int v);   send_cmd({4'h2, 4'h0, 8'(v)}); endtask
    task automatic set_mode(input int v);
        send_cmd({4'h2, 4'h1, 8'(v)});
        m_cpha = v[0]; m_cpol = v[1];
    endtask
    task automatic sel(input int d, input logic [7:0] m); send_cmd({4'h1, 4'(d), m}); endtask
    task automatic xfer(input int fl, input int n);      send_cmd({4'h0, 4'(fl), 8'(n - 1)}); endtask
    task automatic mark(input logic [7:0] id);
        send_cmd({4'h3, 4'h0, id});
        chk(sync_valid && sync_id == id, "R10 marker pulse", int'(sync_id), int'(id));
    endtask
    task automatic push_tx(input logic [7:0] b);
        tx_mem[tx_wr[5:0]] = b;
        tx_wr = tx_wr + 1;
    endtask

    initial begin
        int t0, g, dv, n, rb, sb, tb0;
        logic [7:0] msk, held;
        void'($urandom(32'd4711));

        repeat (4) @(negedge clk);
        chk(cs_n == 8'hFF && sclk == 1'b0 && mosi_oe && !sync_valid, "R2 reset outputs", int'(cs_n), 255);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && cs_n == 8'hFF && sclk == 1'b0 && !rx_valid, "R2 after reset", int'(cmd_ready), 1);

        // R10 marker and single-cycle pulse
        mark(8'h5A);
        @(negedge clk);
        chk(!sync_valid && sync_id == 8'h5A, "R10 pulse width / id held", int'(sync_valid), 0);

        // R9 sleep and R3 select delay timing
        set_div(2);
        send_cmd({4'h3, 4'h1, 8'd3});
        t0 = fetch_cyc;
        mark(8'h11);
        chk(fetch_cyc - t0 == sleep_gap(3, 2), "R9 sleep length", fetch_cyc - t0, sleep_gap(3, 2));
        sel(3, 8'hEF);
        t0 = fetch_cyc;
        chk(cs_n == 8'hEF, "R3 select value", int'(cs_n), 239);
        mark(8'h12);
        chk(fetch_cyc - t0 == sel_gap(3, 2), "R3 select delay", fetch_cyc - t0, sel_gap(3, 2));
        sel(0, 8'hFF);

        // R4 R5 R6: full duplex in all four modes
        for (int m = 0; m < 4; m++) begin
            dv  = int'($urandom % 4);
            n   = 1 + int'($urandom % 6);
            msk = ~(8'd1 << ($urandom % 8));
            set_mode(m);
            set_div(dv);
            rb = rx_n; sb = slv_n; tb0 = tx_wr;
            for (int i = 0; i < n; i++) push_tx(8'($urandom));
            sel(0, msk);
            chk(cs_n == msk, "R3 select value", int'(cs_n), int'(msk));
            xfer(3, n);
            sel(0, 8'hFF);
            mark(8'(8'h20 + m));
            chk(slv_n - sb == n && rx_n - rb == n, "R6 byte count", rx_n - rb, n);
            for (int i = 0; i < n; i++) begin
                chk(slv_got[(sb + i) % 64] == tx_mem[(tb0 + i) % 64], "R5 MOSI byte",
                    int'(slv_got[(sb + i) % 64]), int'(tx_mem[(tb0 + i) % 64]));
                chk(rx_got[(rb + i) % 64] == pat(i), "R5 MISO byte",
                    int'(rx_got[(rb + i) % 64]), int'(pat(i)));
            end
            chk(gap_min == dv + 1, "R4 half period", gap_min, dv + 1);
            chk(sclk == m_cpol, "R5 idle level", int'(sclk), int'(m_cpol));
        end

        // R11 R6: single-line mode, read-only then write-only
        set_mode(4);
        set_div(0);
        rb = rx_n; sb = slv_n;
        sel(0, 8'hFE);
        xfer(2, 2);
        sel(0, 8'hFF);
        mark(8'h30);
        chk(oe_low == 1'b1, "R11 output enable dropped", int'(oe_low), 1);
        chk(slv_got[sb % 64] == 8'h00 && slv_got[(sb + 1) % 64] == 8'h00, "R6 zero fill",
            int'(slv_got[sb % 64]), 0);
        chk(rx_got[rb % 64] == pat(0) && rx_got[(rb + 1) % 64] == pat(1), "R6 read only data",
            int'(rx_got[rb % 64]), int'(pat(0)));
        rb = rx_n; sb = slv_n; tb0 = tx_wr;
        push_tx(8'hC3); push_tx(8'h3C);
        sel(0, 8'hFE);
        xfer(1, 2);
        sel(0, 8'hFF);
        mark(8'h31);
        chk(oe_low == 1'b0 && mosi_oe, "R11 enable kept for writes", int'(oe_low), 0);
        chk(rx_n == rb, "R6 no read offer", rx_n - rb, 0);
        chk(slv_got[sb % 64] == 8'hC3 && slv_got[(sb + 1) % 64] == 8'h3C, "R6 write only data",
            int'(slv_got[sb % 64]), 195);

        // R7: write stream empty stalls the clock
        set_mode(0);
        set_div(1);
        tx_en = 1'b0;
        sb = slv_n;
        push_tx(8'h81); push_tx(8'h7E);
        sel(0, 8'hFD);
        xfer(1, 2);
        repeat (40) @(negedge clk);
        chk(edges == 0 && sclk == 1'b0, "R7 no clock while empty", edges, 0);
        tx_en = 1'b1;
        sel(0, 8'hFF);
        mark(8'h40);
        chk(slv_got[sb % 64] == 8'h81 && slv_got[(sb + 1) % 64] == 8'h7E, "R7 bytes after stall",
            int'(slv_got[sb % 64]), 129);

        // R8: read stream full blocks the next byte
        set_div(0);
        rx_ready = 1'b0;
        rb = rx_n;
        sel(0, 8'hFB);
        xfer(2, 3);
        repeat (60) @(negedge clk);
        chk(rx_valid && rx_data == pat(0), "R8 first byte held", int'(rx_data), int'(pat(0)));
        chk(edges == 16, "R8 no next byte", edges, 16);
        held = rx_data;
        repeat (5) @(negedge clk);
        chk(rx_data == held && edges == 16, "R8 still held", int'(rx_data), int'(held));
        rx_ready = 1'b1;
        sel(0, 8'hFF);
        mark(8'h50);
        chk(rx_n - rb == 3, "R8 all bytes delivered", rx_n - rb, 3);
        for (int i = 0; i < 3; i++)
            chk(rx_got[(rb + i) % 64] == pat(i), "R8 read byte order", int'(rx_got[(rb + i) % 64]), int'(pat(i)));

        // R1: unused opcode, setting target and sub-function change nothing
        set_div(1);
        send_cmd(16'h7123);
        t0 = fetch_cyc;
        send_cmd(16'h2502);
        g = fetch_cyc - t0;
        chk(g == 2, "R1 unused opcode accepted at once", g, 2);
        send_cmd(16'h3F07);
        chk(cs_n == 8'hFF && sclk == 1'b0, "R1 no select or mode change", int'(sclk), 0);
        sb = slv_n;
        push_tx(8'h96);
        sel(0, 8'hBF);
        xfer(1, 1);
        sel(0, 8'hFF);
        mark(8'h60);
        chk(gap_min == 2, "R1 divider untouched", gap_min, 2);
        chk(slv_got[sb % 64] == 8'h96, "R1 mode untouched", int'(slv_got[sb % 64]), 150);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule